// File: doc/BRIEF.md
# Strobed Parallel Digit Writer

This block is the processor-facing write port of a numeric display controller. A bus master presents a digit address, a 4-bit character code, two annunciator bits and a font choice. It then pulses an active-low chip select. While the select is active, the port keeps sampling the inputs into a capture register. When the select is released, the port fires a short internal one-shot. That one-shot decodes the captured code into a seven-segment pattern and stores the pattern, together with the annunciator bits, in the storage word of the addressed digit. Every stored word is visible in parallel at the output, ready for a display multiplexer.

The chip-select inputs are asynchronous to the system clock and pass through a two-stage synchronizer. A guard timer starts at each accepted release. A later release that comes too soon is dropped, and a one-cycle error pulse reports it. In this way a decode is never disturbed by the next strobe. A second chip select can be enabled: the port is then selected only while both selects are low, and releasing either one commits the write.

Top module: `digit_write_port`

## Requirements
- R1: The address, code, annunciator and font inputs present at the end of the selected interval are committed on release of the select. Input changes made 4 or more clock cycles after the release have no effect on the stored word.
- R2: A write changes only the addressed digit. All other digits keep their stored words.
- R3: Address value k writes digit k, which occupies bits [9k+8:9k] of `disp_o`. Address 0 is the first digit.
- R4: With the font input at 1 (hexadecimal), codes 0..15 show 0-9, A, b, C, d, E, F. The segment field is bits [6:0] of each digit word, with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g, active high.
- R5: With the font input at 0 (Code B), codes 0..9 show the decimal digits, and codes 10..15 show '-', E, H, L, P and blank (all segments off).
- R6: `ann_i[0]` is stored in bit 7 of the digit word and `ann_i[1]` in bit 8, unchanged.
- R7: A release that comes fewer than GUARD_CYC clock cycles after the previous accepted release writes nothing and raises `strobe_err_o` for exactly one cycle. A release GUARD_CYC or more cycles later is accepted.
- R8: With the dual-select option, the port is selected only while both `cs_n_i` and `cs2_n_i` are low. An interval with only one select low writes nothing. Releasing either select ends the interval and commits the write.
- R9: After reset every digit word is 0 (all segments and annunciators off) and `strobe_err_o` is low.
- R10: The stored word updates within 8 clock cycles of the select release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Primary chip select, active low, asynchronous |
| cs2_n_i | input | 1 | Secondary chip select, active low, used when DUAL_CS=1 |
| addr_i | input | AW (3) | Digit address |
| data_i | input | 4 | Character code |
| ann_i | input | 2 | Annunciator bits |
| font_hex_i | input | 1 | 1 = hexadecimal font, 0 = Code B font |
| disp_o | output | 9 * 2^AW (72) | Stored digit words, digit k at [9k+8:9k] |
| strobe_err_o | output | 1 | One-cycle pulse when a strobe is rejected by the guard |

## Verification
Random writes draw the address, the code, the annunciators and the font independently. Comparing all digit words after every write separates the decode faults of each font from address-map faults and from disturbance of neighbouring digits. Directed strobes place releases at exactly GUARD_CYC-1 and GUARD_CYC cycles apart, which pins the guard boundary to a single cycle. Two further cases cover dual-select operation: one interval with only one select low, which must not write, and one write committed by releasing the secondary select first. Input changes made after a release show whether the capture closes at the right moment.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int ANN_W  = 2;
  localparam int WORD_W = SEG_W + ANN_W;

  typedef struct packed {
    logic              font_hex;
    logic [ANN_W-1:0]  ann;
    logic [CODE_W-1:0] code;
  } capture_t;

  // segment order in the returned vector: {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [CODE_W-1:0] c);
    case (c)
      4'h0: hex_glyph = 7'h3F;  4'h1: hex_glyph = 7'h06;
      4'h2: hex_glyph = 7'h5B;  4'h3: hex_glyph = 7'h4F;
      4'h4: hex_glyph = 7'h66;  4'h5: hex_glyph = 7'h6D;
      4'h6: hex_glyph = 7'h7D;  4'h7: hex_glyph = 7'h07;
      4'h8: hex_glyph = 7'h7F;  4'h9: hex_glyph = 7'h6F;
      4'hA: hex_glyph = 7'h77;  4'hB: hex_glyph = 7'h7C;
      4'hC: hex_glyph = 7'h39;  4'hD: hex_glyph = 7'h5E;
      4'hE: hex_glyph = 7'h79;  default: hex_glyph = 7'h71;
    endcase
  endfunction

  function automatic logic [SEG_W-1:0] codeb_glyph(input logic [CODE_W-1:0] c);
    case (c)
      4'hA:    codeb_glyph = 7'h40;
      4'hB:    codeb_glyph = 7'h79;
      4'hC:    codeb_glyph = 7'h76;
      4'hD:    codeb_glyph = 7'h38;
      4'hE:    codeb_glyph = 7'h73;
      4'hF:    codeb_glyph = 7'h00;
      default: codeb_glyph = hex_glyph(c);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] build_word(input capture_t cap);
    logic [SEG_W-1:0] seg;
    seg = cap.font_hex ? hex_glyph(cap.code) : codeb_glyph(cap.code);
    build_word = {cap.ann, seg};
  endfunction

endpackage

// File: rtl/dwp_sync.sv
module dwp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dwp_strobe_timer.sv
module dwp_strobe_timer #(
  parameter int PULSE_CYC = 4,
  parameter int GUARD_CYC = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic pulse_on,
  output logic guard_busy,
  output logic reject_q
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int GW = $clog2(GUARD_CYC + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYC - 1);

  logic [PW-1:0] pulse_cnt;
  logic [GW-1:0] guard_cnt;
  logic          accept;

  assign guard_busy = (guard_cnt != '0);
  assign pulse_on   = (pulse_cnt != '0);
  assign accept     = rise && !guard_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      guard_cnt <= '0;
      reject_q  <= 1'b0;
    end else begin
      reject_q <= rise && guard_busy;
      if (accept) begin
        pulse_cnt <= PULSE_LOAD;
        guard_cnt <= GUARD_LOAD;
      end else begin
        if (pulse_on)   pulse_cnt <= pulse_cnt - 1'b1;
        if (guard_busy) guard_cnt <= guard_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwp_digit_bank.sv
module dwp_digit_bank #(
  parameter int AW     = 3,
  parameter int WORD_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [(1<<AW)-1:0]            wr_en,
  output logic [(1<<AW)*WORD_W-1:0]     words
);
  localparam int N = 1 << AW;

  for (genvar i = 0; i < N; i++) begin : g_digit
    logic [WORD_W-1:0] word_q;
    assign wr_en[i] = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (wr_en[i]) word_q <= wdata;
    end
    assign words[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/digit_write_port.sv
module digit_write_port #(
  parameter int AW        = 3,
  parameter int PULSE_CYC = 4,
  parameter int GUARD_CYC = 350,
  parameter bit DUAL_CS   = 1'b1
) (
  input  logic                               clk_i,
  input  logic                               rst_n_i,
  input  logic                               cs_n_i,
  input  logic                               cs2_n_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [dwp_pkg::CODE_W-1:0]         data_i,
  input  logic [dwp_pkg::ANN_W-1:0]          ann_i,
  input  logic                               font_hex_i,
  output logic [(1<<AW)*dwp_pkg::WORD_W-1:0] disp_o,
  output logic                               strobe_err_o
);
  import dwp_pkg::*;
  localparam int NUM_DIGITS = 1 << AW;

  logic [1:0]            cs_sync;
  logic                  sel_act;
  logic                  sel_prev;
  logic                  strobe_rise;
  logic                  pulse_on;
  logic                  guard_busy;
  logic [NUM_DIGITS-1:0] wr_en;
  capture_t              cap_q;
  logic [AW-1:0]         cap_addr_q;

  dwp_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk_i), .rst_n(rst_n_i), .d({cs2_n_i, cs_n_i}), .q(cs_sync)
  );

  if (DUAL_CS) begin : g_dual
    assign sel_act = !cs_sync[0] && !cs_sync[1];
  end else begin : g_single
    assign sel_act = !cs_sync[0];
  end

  assign strobe_rise = sel_prev && !sel_act;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_prev   <= 1'b0;
      cap_q      <= '0;
      cap_addr_q <= '0;
    end else begin
      sel_prev <= sel_act;
      if (sel_act && !pulse_on) begin
        cap_q      <= '{font_hex: font_hex_i, ann: ann_i, code: data_i};
        cap_addr_q <= addr_i;
      end
    end
  end

  dwp_strobe_timer #(.PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC)) u_timer (
    .clk(clk_i), .rst_n(rst_n_i), .rise(strobe_rise),
    .pulse_on(pulse_on), .guard_busy(guard_busy), .reject_q(strobe_err_o)
  );

  dwp_digit_bank #(.AW(AW), .WORD_W(WORD_W)) u_bank (
    .clk(clk_i), .rst_n(rst_n_i), .we(pulse_on), .waddr(cap_addr_q),
    .wdata(build_word(cap_q)), .wr_en(wr_en), .words(disp_o)
  );
endmodule

// File: rtl/dwp_checker.sv
module dwp_checker #(
  parameter int NUM_DIGITS = 8,
  parameter int WORD_W     = 9
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         strobe_rise,
  input logic                         guard_busy,
  input logic                         pulse_on,
  input logic                         strobe_err,
  input logic [NUM_DIGITS-1:0]        wr_en,
  input logic [NUM_DIGITS*WORD_W-1:0] disp
);
  assert_commit_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && !guard_busy) |=> pulse_on);

  assert_hold_between_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_on |=> $stable(disp));

  assert_single_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && guard_busy) |=> strobe_err);

  assert_guard_covers_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> guard_busy);
endmodule

bind digit_write_port dwp_checker #(.NUM_DIGITS(NUM_DIGITS), .WORD_W(dwp_pkg::WORD_W)) u_chk (
  .clk(clk_i), .rst_n(rst_n_i), .strobe_rise(strobe_rise), .guard_busy(guard_busy),
  .pulse_on(pulse_on), .strobe_err(strobe_err_o), .wr_en(wr_en), .disp(disp_o)
);

// File: tb/tb_digit_write_port.sv
module tb_digit_write_port;
  localparam int AW = 3;
  localparam int ND = 1 << AW;
  localparam int GUARD = 350;
  localparam int LOWC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, cs2_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] data = '0;
  logic [1:0] ann = '0;
  logic font = 1'b1;
  logic [ND*9-1:0] disp;
  logic err;

  int total = 0, bad = 0, err_seen = 0;
  bit done = 0;
  logic [8:0] model [ND];

  always #5ns clk = ~clk;

  digit_write_port #(.AW(AW), .PULSE_CYC(4), .GUARD_CYC(GUARD), .DUAL_CS(1'b1)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .cs2_n_i(cs2_n), .addr_i(addr),
    .data_i(data), .ann_i(ann), .font_hex_i(font), .disp_o(disp), .strobe_err_o(err)
  );

  always @(negedge clk) if (rst_n && err) err_seen++;

  function automatic logic [6:0] shape(input byte ch);
    case (ch)
      "0": return 7'h3F; "1": return 7'h06; "2": return 7'h5B; "3": return 7'h4F;
      "4": return 7'h66; "5": return 7'h6D; "6": return 7'h7D; "7": return 7'h07;
      "8": return 7'h7F; "9": return 7'h6F; "A": return 7'h77; "b": return 7'h7C;
      "C": return 7'h39; "d": return 7'h5E; "E": return 7'h79; "F": return 7'h71;
      "-": return 7'h40; "H": return 7'h76; "L": return 7'h38; "P": return 7'h73;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [8:0] expect_word(input logic [3:0] c, input logic [1:0] a, input logic fh);
    string hexs = "0123456789AbCdEF";
    string cbs  = "0123456789-EHLP ";
    byte ch = fh ? hexs[c] : cbs[c];
    return {a, shape(ch)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [ND*9-1:0] act, input logic [ND*9-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ND*9-1:0] model_flat();
    logic [ND*9-1:0] f;
    for (int i = 0; i < ND; i++) f[i*9 +: 9] = model[i];
    return f;
  endfunction

  task automatic check_all(input string tag);
    logic [ND*9-1:0] e = model_flat();
    check(disp === e, tag, disp, e);
  endtask

  task automatic set_in(input logic [AW-1:0] a, input logic [3:0] d, input logic [1:0] an, input logic fh);
    addr = a; data = d; ann = an; font = fh;
  endtask

  task automatic pulse_cs();
    cs_n = 1'b0;
    repeat (LOWC) @(negedge clk);
    cs_n = 1'b1;
  endtask

  // full write: strobe, scramble inputs after release, check after settling
  task automatic do_write(input logic [AW-1:0] a, input logic [3:0] d, input logic [1:0] an,
                          input logic fh, input string tag);
    set_in(a, d, an, fh);
    pulse_cs();
    repeat (4) @(negedge clk);
    set_in(~a, ~d, ~an, ~fh);
    repeat (4) @(negedge clk);
    model[a] = expect_word(d, an, fh);
    check_all(tag);
    repeat (GUARD) @(negedge clk);
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0;
    void'($urandom(32'd4242));
    for (int i = 0; i < ND; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9 reset words");
    check(err === 1'b0, "R9 reset err", {71'd0, err}, '0);

    // R4 every hex code, R5 every Code B code, R3 on every address
    for (int c = 0; c < 16; c++) do_write(AW'(c % ND), 4'(c), 2'b00, 1'b1, "R4 hex font R3");
    for (int c = 0; c < 16; c++) do_write(AW'((c + 3) % ND), 4'(c), 2'b00, 1'b0, "R5 codeB font R3");
    // R6 annunciator combinations
    for (int a = 0; a < 4; a++) do_write(AW'(a + 4), 4'h8, 2'(a), 1'b0, "R6 annunciators");

    // R1 data change after release does not leak (do_write scrambles inputs)
    do_write(3'd7, 4'h2, 2'b10, 1'b1, "R1 commit at release R10");

    // R7 guard: release at GUARD-1 cycles rejected
    e0 = err_seen;
    set_in(3'd1, 4'h5, 2'b01, 1'b1);
    pulse_cs();
    repeat (GUARD - 1 - LOWC) @(negedge clk);
    model[1] = expect_word(4'h5, 2'b01, 1'b1);
    set_in(3'd2, 4'h9, 2'b11, 1'b1);
    pulse_cs();
    repeat (8) @(negedge clk);
    check_all("R7 early strobe ignored R2");
    check(err_seen == e0 + 1, "R7 error pulse once", 72'(err_seen - e0), 72'd1);
    repeat (GUARD) @(negedge clk);

    // R7 guard: release at exactly GUARD cycles accepted
    e0 = err_seen;
    set_in(3'd3, 4'hA, 2'b00, 1'b0);
    pulse_cs();
    repeat (GUARD - LOWC) @(negedge clk);
    model[3] = expect_word(4'hA, 2'b00, 1'b0);
    set_in(3'd6, 4'hD, 2'b01, 1'b1);
    pulse_cs();
    repeat (8) @(negedge clk);
    model[6] = expect_word(4'hD, 2'b01, 1'b1);
    check_all("R7 boundary strobe accepted");
    check(err_seen == e0, "R7 no error at boundary", 72'(err_seen - e0), 72'd0);
    repeat (GUARD) @(negedge clk);

    // R8 only primary select low: no write
    cs2_n = 1'b1;
    set_in(3'd0, 4'h1, 2'b11, 1'b1);
    pulse_cs();
    repeat (8) @(negedge clk);
    check_all("R8 single select no write");
    repeat (GUARD) @(negedge clk);

    // R8 release of secondary select commits
    cs2_n = 1'b0;
    set_in(3'd5, 4'hC, 2'b10, 1'b0);
    cs_n = 1'b0;
    repeat (LOWC) @(negedge clk);
    cs2_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    model[5] = expect_word(4'hC, 2'b10, 1'b0);
    check_all("R8 secondary release commits");
    cs2_n = 1'b0;
    repeat (GUARD) @(negedge clk);

    // random writes: R2 R3 R4 R5 R6
    for (int n = 0; n < 120; n++)
      do_write(AW'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), "R2 R3 random write");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule